// File: doc/BRIEF.md
# Dominant Time-out Transmit Gate

This block sits between a protocol controller's transmit data line and the enable of a single-wire bus driver. It decides, every clock, whether the driver may act and which level it sends. A LOW transmit input means a dominant bus level and a HIGH input means recessive. When the driver is not allowed to act, the block presents the recessive level.

The driver is blocked in four cases. The first is a transmit input that has stayed LOW for longer than a programmable number of clock cycles, which protects the bus from a stuck controller pin. The second is a low enable input. The third is an asserted (LOW) reset-output level. The fourth is a fresh entry into the active operating mode before the transmit line has been seen recessive at least once.

A sticky status bit reports that the time-out has fired. It stays set while the line remains LOW and clears when the line returns HIGH. The transmit input is expected to be synchronized already. Its history register resets to HIGH, as though an idle pull-up held the line.

Top module: `dom_timeout_gate`

## Requirements
- R1: While `rst_n` is LOW, and in the first cycle after it is released, `drv_en_o` is 0, `tx_level_o` is 1 and `dto_flag_o` is 0.
- R2: While `drv_en_o` is 1, `tx_level_o` equals `txd_i`, where 0 is dominant and 1 is recessive. While `drv_en_o` is 0, `tx_level_o` is 1.
- R3: `drv_en_o` is 0 in any cycle in which `en_i` is 0 or `rstout_i` is 0, and it follows these inputs in the same cycle.
- R4: After `act_mode_i` rises, `drv_en_o` stays 0 until `txd_i` has been sampled HIGH at a clock edge with `act_mode_i` at 1. The driver may be enabled from the cycle that follows that edge.
- R5: A clock edge with `act_mode_i` at 0 clears the arming. The rule in R4 then applies again on the next entry into the active mode.
- R6: When `txd_i` has been sampled LOW at `DTO_CYCLES` consecutive clock edges, `dto_flag_o` is 1 after the last of those edges and `drv_en_o` is 0.
- R7: A LOW run of `DTO_CYCLES`-1 samples or fewer, ended by a HIGH sample, never sets `dto_flag_o`.
- R8: `dto_flag_o` stays 1 while `txd_i` stays LOW. It returns to 0 after the first edge at which `txd_i` is sampled HIGH. The next LOW run is then counted from zero.
- R9: The dominant run is measured whatever the values of `act_mode_i`, `en_i` and `rstout_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| txd_i | input | 1 | Synchronized transmit data, 0 = dominant |
| act_mode_i | input | 1 | 1 while the transceiver is in its active (Normal) mode |
| en_i | input | 1 | Enable level |
| rstout_i | input | 1 | Level of the reset output, 0 = reset asserted |
| drv_en_o | output | 1 | Bus driver enable |
| tx_level_o | output | 1 | Effective transmit level, 0 = dominant |
| dto_flag_o | output | 1 | Sticky dominant time-out status |

## Verification
A wrong run counter first shows as `dto_flag_o` rising one or more cycles early or late relative to the `DTO_CYCLES`-th LOW sample. The same error shows on `drv_en_o` in that cycle, because the flag blocks the driver. Missing arming state shows as `drv_en_o` going high in the first active-mode cycle while `txd_i` is still LOW. It also shows as the driver staying enabled through a mode exit and re-entry. A reference model in the bench predicts all three outputs every clock, so any such divergence is reported in the cycle in which it first appears.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Arming state of the driver after entry to the active mode
    typedef struct packed {
        logic armed;
    } dtg_arm_t;

    // Driver is allowed to act only when every permission holds
    function automatic logic dtg_permit(input logic armed,
                                        input logic act_mode,
                                        input logic en,
                                        input logic rstout,
                                        input logic dto);
        return armed & act_mode & en & rstout & ~dto;
    endfunction

endpackage

// File: rtl/dtg_run_timer.sv
module dtg_run_timer #(
    parameter int unsigned DTO_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    output logic dto_o
);
    localparam int unsigned CW = (DTO_CYCLES > 2) ? $clog2(DTO_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DTO_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          dto;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (txd_i) begin
            // recessive sample: restart the run and drop the status
            s_d.run = '0;
            s_d.dto = 1'b0;
        end else if (s_q.run == LAST) begin
            s_d.dto = 1'b1;
        end else begin
            s_d.run = s_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dto_o = s_q.dto;

    p_flag_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txd_i |=> !dto_o);
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dto_o && !txd_i) |=> dto_o);
    p_set_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dto_o) |-> !$past(txd_i));

endmodule

// File: rtl/dtg_arm.sv
module dtg_arm
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic act_mode_i,
    output logic armed_o
);
    dtg_arm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!act_mode_i)  s_d.armed = 1'b0;
        else if (txd_i)   s_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign armed_o = s_q.armed;

    p_arm_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> ($past(txd_i) && $past(act_mode_i)));
    p_disarm_on_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !act_mode_i |=> !armed_o);

endmodule

// File: rtl/dom_timeout_gate.sv
module dom_timeout_gate
    import dtg_pkg::*;
#(
    parameter int unsigned DTO_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic act_mode_i,
    input  logic en_i,
    input  logic rstout_i,
    output logic drv_en_o,
    output logic tx_level_o,
    output logic dto_flag_o
);
    logic dto_w;
    logic armed_w;

    dtg_run_timer #(.DTO_CYCLES(DTO_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .txd_i (txd_i),
        .dto_o (dto_w)
    );

    dtg_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .txd_i      (txd_i),
        .act_mode_i (act_mode_i),
        .armed_o    (armed_w)
    );

    always_comb begin
        drv_en_o   = dtg_permit(armed_w, act_mode_i, en_i, rstout_i, dto_w);
        tx_level_o = drv_en_o ? txd_i : 1'b1;
        dto_flag_o = dto_w;
    end

    p_timeout_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dto_flag_o |-> !drv_en_o);
    p_unarmed_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_w |-> !drv_en_o);

    initial begin
        p_param_ok_r6: assert (DTO_CYCLES >= 2);
    end

endmodule

// File: tb/sim_dom_timeout_gate.sv
`timescale 1ns/1ps
module sim_dom_timeout_gate;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, act = 1'b0, en = 1'b0, ro = 1'b0;
    logic drv, lvl, flg;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    int run = 0;
    bit m_armed = 0, m_flag = 0;

    always #2.5 clk = ~clk;

    dom_timeout_gate #(.DTO_CYCLES(T)) u0 (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .act_mode_i(act),
        .en_i(en), .rstout_i(ro),
        .drv_en_o(drv), .tx_level_o(lvl), .dto_flag_o(flg)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 0; m_armed <= 0; m_flag <= 0;
        end else begin
            if (txd) begin
                run <= 0; m_flag <= 0;
            end else begin
                run <= run + 1;
                if (run + 1 >= T) m_flag <= 1;
            end
            m_armed <= act && (m_armed || txd);
        end
    end

    task automatic chk(string req, string what, logic actual, logic expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            automatic logic e_drv = m_armed & act & en & ro & ~m_flag;
            chk(cur_req, "drv_en_o", drv, e_drv);
            chk(cur_req, "tx_level_o", lvl, e_drv ? txd : 1'b1);
            chk(cur_req, "dto_flag_o", flg, m_flag);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        cur_req = "R1";
        cyc(3);
        chk("R1", "drv reset", drv, 1'b0);
        chk("R1", "lvl reset", lvl, 1'b1);
        chk("R1", "flag reset", flg, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "drv after release", drv, 1'b0);

        // R4: enter active mode with TXD low
        cur_req = "R4";
        en = 1; ro = 1; txd = 0; act = 1;
        cyc(3);
        #1 chk("R4", "not armed while low", drv, 1'b0);
        txd = 1;
        #1 chk("R4", "not yet armed same cycle", drv, 1'b0);
        cyc(1);
        #1 chk("R4", "armed after high sample", drv, 1'b1);

        // R2: data pattern through the gate
        cur_req = "R2";
        for (int i = 0; i < 16; i++) begin
            txd = (i % 3 == 0) ? 1'b0 : 1'b1;
            cyc(1);
            #1 chk("R2", "level follows txd", lvl, txd);
        end
        txd = 1; cyc(1);

        // R3: enable and reset-output gating
        cur_req = "R3";
        en = 0; txd = 0;
        #1 chk("R3", "en low blocks", drv, 1'b0);
        chk("R3", "en low recessive", lvl, 1'b1);
        cyc(2); en = 1; txd = 1; cyc(1);
        ro = 0;
        #1 chk("R3", "rstout low blocks", drv, 1'b0);
        cyc(2); ro = 1; cyc(1);
        #1 chk("R3", "restored", drv, 1'b1);

        // R7: one short of the limit
        cur_req = "R7";
        txd = 0; cyc(T - 1);
        #1 chk("R7", "no flag at T-1", flg, 1'b0);
        chk("R7", "still dominant", lvl, 1'b0);
        txd = 1; cyc(1);
        #1 chk("R7", "no flag after run", flg, 1'b0);

        // R6 / R8: full time-out, stickiness, clearing
        cur_req = "R6";
        txd = 0; cyc(T);
        #1 chk("R6", "flag at T", flg, 1'b1);
        chk("R6", "driver off", drv, 1'b0);
        chk("R6", "recessive", lvl, 1'b1);
        cur_req = "R8";
        cyc(7);
        #1 chk("R8", "flag sticky", flg, 1'b1);
        txd = 1; cyc(1);
        #1 chk("R8", "flag cleared", flg, 1'b0);
        chk("R8", "driver back", drv, 1'b1);
        txd = 0; cyc(T - 1);
        #1 chk("R8", "fresh count", flg, 1'b0);
        txd = 1; cyc(1);

        // R5: mode exit and re-entry with TXD low
        cur_req = "R5";
        act = 0; cyc(1);
        txd = 0; act = 1; cyc(2);
        #1 chk("R5", "disarmed on re-entry", drv, 1'b0);
        txd = 1; cyc(1);
        #1 chk("R5", "rearmed", drv, 1'b1);

        // R9: time-out measured outside active mode and with enable low
        cur_req = "R9";
        act = 0; en = 0; txd = 0; cyc(T);
        #1 chk("R9", "flag outside mode", flg, 1'b1);
        txd = 1; cyc(1);
        #1 chk("R9", "cleared outside mode", flg, 1'b0);
        cyc(2);
        summary();
    end
endmodule